// File: doc/BRIEF.md
# Pad Input Event Detector

This block is the receive-side event path of a single general-purpose pad. The raw pad level is brought into the core clock domain through a synchronizer. It can then be inverted, and it can optionally be filtered against a slow timebase tick so that only levels held long enough are accepted. The filtered value feeds an event detector whose trigger kind comes from a configuration word. When an event is seen, a sticky status flag is set, and that flag is copied onto any of four interrupt target outputs.

Software writes one 16-bit configuration word with a single write strobe and clears the status flag with a one-cycle clear strobe. The sampled pad value and the configured drive value are visible as outputs.

Configuration word layout, which the bench depends on:

| Bits | Field |
|------|-------|
| [1:0] | trigger kind |
| [2] | invert |
| [3] | receiver disable |
| [7:4] | target enables, bit 4+i enabling target i |
| [8] | filter enable |
| [12:9] | filter length code |
| [13] | drive value |
| [15:14] | unused |

Top module: `pad_evt_det`

## Requirements
- R1: After a synchronous reset, evt_sts, route_irq, rx_state and tx_state are all 0 and the configuration word is 0.
- R2: rx_state shows pad_raw, not inverted, two clock cycles after it is sampled, through a two-flop synchronizer.
- R3: When configuration bit 2 (invert) is 1, the synchronized value is inverted before filtering and event evaluation, so a low pad counts as active.
- R4: Trigger code 0 (level) sets evt_sts on every cycle in which the filtered value is 1. A clear made while the level persists is followed by re-assertion on the next cycle.
- R5: Trigger code 1 (single edge) sets evt_sts only on a 0-to-1 change of the filtered value. With invert off this is a rising pad edge; with invert on it is a falling pad edge.
- R6: Trigger code 3 sets evt_sts on any change of the filtered value.
- R7: Trigger code 2 never sets evt_sts.
- R8: When configuration bit 3 (receiver disable) is 1, evt_sts is never set, whatever the pad does.
- R9: When configuration bit 8 (filter enable) is 1, a new value is accepted only after it has differed from the accepted value for 2^code consecutive slow_tick pulses. Here code is bits [12:9], and codes below 3 act as 3. A return to the accepted value restarts the count, and the count advances only on slow_tick.
- R10: route_irq[i] is 1 exactly when, one cycle earlier, evt_sts was 1 and configuration bit 4+i was 1. Any combination of targets may be enabled at once.
- R11: evt_sts is sticky: it holds 1 until a cycle with sts_clr high, after which it reads 0 unless a new event is present. A clear wins over an event in the same cycle.
- R12: A configuration write that changes the trigger code, the filter enable or the filter length reloads the edge history and restarts the filter count, so the change alone raises no edge event.
- R13: tx_state shows configuration bit 13 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous active-high reset |
| pad_raw | input | 1 | asynchronous pad receive level |
| slow_tick | input | 1 | one-cycle pulse of the slow filter timebase |
| cfg_we | input | 1 | configuration write strobe |
| cfg_wdata | input | 16 | configuration word |
| sts_clr | input | 1 | write-one clear of the status flag |
| evt_sts | output | 1 | sticky event status |
| rx_state | output | 1 | synchronized pad value |
| tx_state | output | 1 | configured drive value |
| route_irq | output | 4 | per-target interrupt outputs |

## Verification
The bench holds a level-mode input high while it clears the flag, so it checks that the flag comes back one cycle later. A clear that acted as a mask would leave the flag low instead. It flips the invert bit in single-edge mode, so a detector hard-wired to rising pad edges would miss the falling pad edge. It also moves the trigger code from off to edge while the pad is held high; a design that keeps stale history would fire a false event. For the filter, it sends glitches shorter than 2^code ticks, which a counter that fails to restart would wrongly accept, and it uses a code below 3, which an unclamped limit would pass after too few ticks.

// File: rtl/pad_evt_pkg.sv
package pad_evt_pkg;

  localparam int CFG_W      = 16;
  localparam int NUM_ROUTES = 4;
  localparam int CODE_W     = 4;
  localparam int MIN_CODE   = 3;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_OFF   = 2'd2,
    TRIG_ANY   = 2'd3
  } trig_e;

  typedef struct packed {
    logic [1:0]            spare;
    logic                  drive_val;
    logic [CODE_W-1:0]     flt_code;
    logic                  flt_en;
    logic [NUM_ROUTES-1:0] route_en;
    logic                  rx_off;
    logic                  invert;
    trig_e                 trig;
  } cfg_t;

endpackage

// File: rtl/pad_evt_sync.sv
module pad_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pad_evt_filter.sv
module pad_evt_filter #(
  parameter int CODE_W   = 4,
  parameter int MIN_CODE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic              tick,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              filt_d,
  output logic              filt_q
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CODE_W-1:0] eff_code;
  logic [CNT_W:0]    last_cnt;

  always_comb begin
    eff_code = (code < CODE_W'(MIN_CODE)) ? CODE_W'(MIN_CODE) : code;
    last_cnt = ((CNT_W+1)'(1) << eff_code) - (CNT_W+1)'(1);
  end

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (!en) begin
      filt_d = din;
      cnt_d  = '0;
    end else if (restart || din == filt_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if ({1'b0, cnt_q} == last_cnt) begin
        filt_d = din;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/pad_evt_trig.sv
module pad_evt_trig
  import pad_evt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  filt_q,
  input  logic  filt_d,
  input  trig_e trig,
  input  logic  rx_off,
  input  logic  hist_load,
  input  logic  clr,
  output logic  sts_q
);
  logic prev_q;
  logic evt;

  always_comb begin
    unique case (trig)
      TRIG_LEVEL: evt = filt_q;
      TRIG_RISE:  evt = filt_q & ~prev_q;
      TRIG_ANY:   evt = filt_q ^ prev_q;
      default:    evt = 1'b0;
    endcase
    if (rx_off) evt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      prev_q <= hist_load ? filt_d : filt_q;
      sts_q  <= clr ? 1'b0 : (sts_q | evt);
    end
  end
endmodule

// File: rtl/pad_evt_det.sv
module pad_evt_det
  import pad_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pad_raw,
  input  logic                  slow_tick,
  input  logic                  cfg_we,
  input  logic [CFG_W-1:0]      cfg_wdata,
  input  logic                  sts_clr,
  output logic                  evt_sts,
  output logic                  rx_state,
  output logic                  tx_state,
  output logic [NUM_ROUTES-1:0] route_irq
);
  cfg_t cfg_q;
  cfg_t cfg_new;
  logic sync_q;
  logic polar;
  logic filt_d, filt_q;
  logic hist_load;
  logic sts_q;
  logic [NUM_ROUTES-1:0] route_q;

  assign cfg_new = cfg_t'(cfg_wdata);

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= cfg_t'('0);
    else if (cfg_we) cfg_q <= cfg_new;
  end

  assign hist_load = cfg_we && ((cfg_new.trig != cfg_q.trig) ||
                                (cfg_new.flt_en != cfg_q.flt_en) ||
                                (cfg_new.flt_code != cfg_q.flt_code));

  pad_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_raw), .q(sync_q)
  );

  assign polar = sync_q ^ cfg_q.invert;

  pad_evt_filter #(.CODE_W(CODE_W), .MIN_CODE(MIN_CODE)) u_filt (
    .clk(clk), .rst(rst), .din(polar), .tick(slow_tick),
    .en(cfg_q.flt_en), .code(cfg_q.flt_code), .restart(hist_load),
    .filt_d(filt_d), .filt_q(filt_q)
  );

  pad_evt_trig u_trig (
    .clk(clk), .rst(rst), .filt_q(filt_q), .filt_d(filt_d),
    .trig(cfg_q.trig), .rx_off(cfg_q.rx_off), .hist_load(hist_load),
    .clr(sts_clr), .sts_q(sts_q)
  );

  for (genvar g = 0; g < NUM_ROUTES; g++) begin : g_route
    always_ff @(posedge clk) begin
      if (rst) route_q[g] <= 1'b0;
      else     route_q[g] <= sts_q & cfg_q.route_en[g];
    end
  end

  assign evt_sts   = sts_q;
  assign rx_state  = sync_q;
  assign tx_state  = cfg_q.drive_val;
  assign route_irq = route_q;
endmodule

// File: rtl/pad_evt_chk.sv
module pad_evt_chk
  import pad_evt_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  sts,
  input logic                  clr,
  input logic                  tick,
  input logic                  filt,
  input logic [CFG_W-1:0]      cfg,
  input logic [NUM_ROUTES-1:0] route_irq
);
  cfg_t c;
  assign c = cfg_t'(cfg);

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> !sts);

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (sts && !clr) |=> sts);

  a_r7_r8_no_set: assert property (@(posedge clk) disable iff (rst)
    $rose(sts) |-> $past(c.trig != TRIG_OFF && !c.rx_off));

  a_r10_route_needs_sts: assert property (@(posedge clk) disable iff (rst)
    (route_irq != '0) |-> $past(sts));

  a_r10_route_mask: assert property (@(posedge clk) disable iff (rst)
    (route_irq & ~$past(c.route_en)) == '0);

  a_r9_tick_only: assert property (@(posedge clk) disable iff (rst)
    (!$stable(filt) && $past(c.flt_en)) |-> $past(tick));
endmodule

bind pad_evt_det pad_evt_chk u_chk (
  .clk(clk), .rst(rst), .sts(evt_sts), .clr(sts_clr), .tick(slow_tick),
  .filt(filt_q), .cfg(cfg_q), .route_irq(route_irq)
);

// File: tb/tb_pad_evt_det.sv
module tb_pad_evt_det;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pad_raw = 1'b0;
  logic slow_tick = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic sts_clr = 1'b0;
  logic evt_sts, rx_state, tx_state;
  logic [3:0] route_irq;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  bit tick_on = 1'b0;
  int tick_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_evt_det dut (
    .clk(clk), .rst(rst), .pad_raw(pad_raw), .slow_tick(slow_tick),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .sts_clr(sts_clr),
    .evt_sts(evt_sts), .rx_state(rx_state), .tx_state(tx_state),
    .route_irq(route_irq)
  );

  // Behavioural reference state
  int m_s1, m_s2, m_filt, m_prev, m_sts, m_ticks;
  int m_route_out;
  int m_trig, m_inv, m_off, m_routes, m_fen, m_code, m_drive;

  function automatic int needed_ticks(int code);
    int e;
    e = (code < 3) ? 3 : code;
    return 2 ** e;
  endfunction

  always @(posedge clk) begin
    int v, nf, nt, ev, ntrig, nfen, ncode;
    bit reload;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_filt = 0; m_prev = 0; m_sts = 0; m_ticks = 0;
      m_route_out = 0; m_trig = 0; m_inv = 0; m_off = 0; m_routes = 0;
      m_fen = 0; m_code = 0; m_drive = 0;
    end else begin
      v = (m_s2 != m_inv) ? 1 : 0;
      ntrig = cfg_wdata[1:0]; nfen = cfg_wdata[8]; ncode = cfg_wdata[12:9];
      reload = cfg_we && (ntrig != m_trig || nfen != m_fen || ncode != m_code);
      nf = m_filt; nt = m_ticks;
      if (m_fen == 0) begin nf = v; nt = 0; end
      else if (reload || v == m_filt) nt = 0;
      else if (slow_tick) begin
        if (m_ticks + 1 >= needed_ticks(m_code)) begin nf = v; nt = 0; end
        else nt = m_ticks + 1;
      end
      ev = 0;
      if (m_off == 0) begin
        if (m_trig == 0) ev = m_filt;
        else if (m_trig == 1) ev = (m_filt == 1 && m_prev == 0) ? 1 : 0;
        else if (m_trig == 3) ev = (m_filt != m_prev) ? 1 : 0;
      end
      m_route_out = m_sts ? m_routes : 0;
      m_sts = sts_clr ? 0 : ((m_sts != 0 || ev != 0) ? 1 : 0);
      m_prev = reload ? nf : m_filt;
      m_filt = nf; m_ticks = nt;
      if (cfg_we) begin
        m_trig = ntrig; m_inv = cfg_wdata[2]; m_off = cfg_wdata[3];
        m_routes = cfg_wdata[7:4]; m_fen = nfen; m_code = ncode;
        m_drive = cfg_wdata[13];
      end
      m_s2 = m_s1; m_s1 = pad_raw;
    end
    #(CLK_PERIOD/4);
    vectors++;
    if (evt_sts !== m_sts[0] || route_irq !== 4'(m_route_out) ||
        rx_state !== m_s2[0] || tx_state !== m_drive[0]) begin
      miscompares++;
      $display("FAIL %s t=%0t sts=%b/%0d route=%b/%0h rx=%b/%0d tx=%b/%0d (actual/expected)",
               cur_req, $time, evt_sts, m_sts, route_irq, m_route_out,
               rx_state, m_s2, tx_state, m_drive);
    end
  end

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 3;
    slow_tick <= tick_on && (tick_cnt == 0);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(int trig, int inv, int off, int routes,
                      int fen, int code, int drive);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 16'(trig | (inv << 2) | (off << 3) | (routes << 4) |
                    (fen << 8) | (code << 9) | (drive << 13));
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_sts;
    @(negedge clk);
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
  endtask

  task automatic set_pad(bit v);
    @(negedge clk);
    pad_raw = v;
  endtask

  task automatic direct(string req, bit got, bit exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s directed actual=%b expected=%b", req, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    cyc(4);
    rst = 1'b0;
    cyc(1);
    direct("R1", evt_sts, 1'b0);
    direct("R1", tx_state, 1'b0);

    cur_req = "R13";
    wcfg(2, 0, 0, 0, 0, 0, 1);
    direct("R13", tx_state, 1'b1);

    cur_req = "R2";
    set_pad(1);
    cyc(2);
    direct("R2", rx_state, 1'b1);

    cur_req = "R7";
    for (int i = 0; i < 4; i++) begin set_pad(i % 2 == 0 ? 0 : 1); cyc(3); end
    direct("R7", evt_sts, 1'b0);

    cur_req = "R4";
    set_pad(0);
    cyc(3);
    wcfg(0, 0, 0, 0, 0, 0, 0);
    set_pad(1);
    cyc(6);
    direct("R4", evt_sts, 1'b1);
    clear_sts();
    cyc(2);
    direct("R4", evt_sts, 1'b1);
    set_pad(0);
    cyc(4);
    clear_sts();
    cyc(3);
    direct("R4", evt_sts, 1'b0);

    cur_req = "R5";
    wcfg(1, 0, 0, 0, 0, 0, 0);
    set_pad(1);
    cyc(5);
    direct("R5", evt_sts, 1'b1);
    clear_sts();
    set_pad(0);
    cyc(5);
    direct("R5", evt_sts, 1'b0);
    wcfg(1, 1, 0, 0, 0, 0, 0);
    cyc(4);
    clear_sts();
    set_pad(1);
    cyc(5);
    direct("R5", evt_sts, 1'b0);
    set_pad(0);
    cyc(5);
    direct("R5", evt_sts, 1'b1);

    cur_req = "R11";
    cyc(10);
    direct("R11", evt_sts, 1'b1);
    clear_sts();
    cyc(1);
    direct("R11", evt_sts, 1'b0);

    cur_req = "R6";
    wcfg(3, 0, 0, 0, 0, 0, 0);
    cyc(4);
    clear_sts();
    set_pad(1);
    cyc(5);
    direct("R6", evt_sts, 1'b1);
    clear_sts();
    set_pad(0);
    cyc(5);
    direct("R6", evt_sts, 1'b1);

    cur_req = "R3";
    wcfg(0, 1, 0, 0, 0, 0, 0);
    cyc(4);
    clear_sts();
    cyc(2);
    direct("R3", evt_sts, 1'b1);
    set_pad(1);
    cyc(4);
    clear_sts();
    cyc(3);
    direct("R3", evt_sts, 1'b0);

    cur_req = "R8";
    wcfg(3, 0, 1, 4'hF, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin set_pad(i % 2 == 0 ? 0 : 1); cyc(3); end
    direct("R8", evt_sts, 1'b0);

    cur_req = "R10";
    wcfg(0, 0, 0, 4'b0101, 0, 0, 0);
    set_pad(1);
    cyc(6);
    wcfg(0, 0, 0, 4'b1000, 0, 0, 0);
    cyc(3);
    wcfg(0, 0, 0, 4'b1111, 0, 0, 0);
    cyc(3);
    direct("R10", route_irq[2], 1'b1);
    set_pad(0);
    cyc(3);
    clear_sts();
    cyc(3);

    cur_req = "R12";
    wcfg(2, 0, 0, 4'b0011, 0, 0, 0);
    set_pad(1);
    cyc(6);
    wcfg(1, 0, 0, 4'b0011, 0, 0, 0);
    cyc(6);
    direct("R12", evt_sts, 1'b0);
    wcfg(3, 0, 0, 4'b0011, 0, 0, 0);
    cyc(6);
    direct("R12", evt_sts, 1'b0);

    cur_req = "R9";
    tick_on = 1'b1;
    set_pad(0);
    cyc(4);
    wcfg(1, 0, 0, 4'b0001, 1, 3, 0);
    clear_sts();
    set_pad(1);
    cyc(12);
    set_pad(0);
    cyc(4);
    set_pad(1);
    cyc(12);
    set_pad(0);
    cyc(30);
    direct("R9", evt_sts, 1'b0);
    set_pad(1);
    cyc(40);
    direct("R9", evt_sts, 1'b1);
    wcfg(1, 0, 0, 4'b0001, 1, 0, 0);
    clear_sts();
    set_pad(0);
    cyc(40);
    set_pad(1);
    cyc(15);
    direct("R9", evt_sts, 1'b0);
    cyc(25);
    direct("R9", evt_sts, 1'b1);
    wcfg(3, 0, 0, 4'b0001, 1, 5, 0);
    clear_sts();
    set_pad(0);
    cyc(60);
    direct("R9", evt_sts, 1'b0);
    cyc(60);
    direct("R9", evt_sts, 1'b1);

    cur_req = "R1";
    @(negedge clk);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    direct("R1", evt_sts, 1'b0);
    direct("R1", route_irq == 4'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule